// File: doc/BRIEF.md
# Flash power mode controller

This block follows the power state of a serial flash device. The state is selected-and-running (active), idle-and-deselected (standby) or deep power-down. Its inputs are the chip-select pin, the device reset pin and a one-cycle strobe that carries each decoded opcode. A busy flag from the internal write, program and erase engine is also an input. The block reports the current mode. It tells the downstream instruction decoder which strobes may take effect, and it raises a write-protect signal while the reset pin is low.

Entry into and exit from deep power-down are set up by a complete instruction during a selection. They take effect on the clock edge that sees chip select go high. Only the last instruction of a selection counts. Deselecting the part does not drop it to standby while the engine is still busy. In deep power-down, every instruction except the release instruction is rejected. The block runs on a synchronous active-high reset. The device reset pin only gates instructions and does not reset the block.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: While `cs_n` is low at a clock edge and the mode is not deep power-down, `mode` reads active (2'b00) after that edge.
- R2: While `cs_n` stays high and `engine_busy` is high, an active mode stays active. After the first edge with `cs_n` high and `engine_busy` low, the mode reads standby (2'b01).
- R3: A deep power-down opcode (parameter `DPD_OP`, default 8'hB9) that is accepted while selected moves `mode` to deep power-down (2'b10). The move happens on the edge where `cs_n` is first seen high, provided it was the last accepted instruction of that selection.
- R4: In deep power-down, `instr_accept` is low for every opcode except the release opcode, and `mode` stays deep power-down whatever `cs_n` does.
- R5: A release opcode (parameter `REL_OP`, default 8'hAB) that is accepted in deep power-down moves `mode` to standby on the edge where `cs_n` is first seen high.
- R6: While `dev_rst_n` is low, `write_protect` is high and the write-class opcodes 8'h06, 8'h02, 8'h0A, 8'hDB and 8'hD8 are not accepted. Other opcodes are still accepted.
- R7: A deep power-down opcode that arrives while `engine_busy` is high is not accepted and leaves the mode unchanged.
- R8: During and right after `rst`, `mode` reads standby if `cs_n` is high and active if it is low.
- R9: `instr_accept` is high only while `instr_valid` is high and `cs_n` is low. A later accepted opcode in the same selection cancels an earlier deep power-down or release request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low = selected |
| dev_rst_n | input | 1 | Device reset pin, low blocks writes |
| instr_valid | input | 1 | One-cycle strobe of a complete decoded instruction |
| instr_op | input | 8 | Opcode carried by the strobe |
| engine_busy | input | 1 | Internal write/program/erase cycle running |
| mode | output | 2 | 00 active, 01 standby, 10 deep power-down |
| instr_accept | output | 1 | Strobe may take effect downstream |
| write_protect | output | 1 | Write-class instructions blocked |

## Verification
Two functions can meet on the same cycle. One is the chip-select rising edge that would apply a pending deep power-down request. The other is the busy check that holds an active mode when the part is deselected. The bench sets up a power-down request, then raises `cs_n` while `engine_busy` is high. The required result is deep power-down. A deep power-down strobe that arrives while busy is high must instead be refused and leave the part active. A cycle-accurate behavioural model checks the mode and the accept signal on every clock while the inputs are driven at random, and it checks these collisions many times over.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

    localparam int OP_W    = 8;
    localparam int MODE_W  = 2;
    localparam int N_WROPS = 5;

    typedef enum logic [MODE_W-1:0] {
        PM_ACTIVE  = 2'b00,
        PM_STANDBY = 2'b01,
        PM_DEEP    = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic is_dpd;
        logic is_rel;
        logic is_write;
    } op_class_t;

    typedef logic [OP_W-1:0] op_t;

    localparam op_t WRITE_OPS [N_WROPS] = '{8'h06, 8'h02, 8'h0A, 8'hDB, 8'hD8};

    function automatic logic op_is_write(input op_t op);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_WROPS; i++) begin
            if (op == WRITE_OPS[i]) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/flash_pwr_decode.sv
module flash_pwr_decode
    import flash_pwr_pkg::*;
#(
    parameter op_t DPD_OP = 8'hB9,
    parameter op_t REL_OP = 8'hAB
) (
    input  pm_mode_e  cur_mode,
    input  logic      cs_n,
    input  logic      dev_rst_n,
    input  logic      instr_valid,
    input  op_t       instr_op,
    input  logic      engine_busy,
    output op_class_t cls,
    output logic      accept
);

    logic allowed;

    always_comb begin
        cls.is_dpd   = (instr_op == DPD_OP);
        cls.is_rel   = (instr_op == REL_OP);
        cls.is_write = op_is_write(instr_op);
    end

    always_comb begin
        if (cur_mode == PM_DEEP) begin
            allowed = cls.is_rel;
        end else begin
            allowed = !(cls.is_dpd && engine_busy) && !(cls.is_write && !dev_rst_n);
        end
        accept = instr_valid && !cs_n && allowed;
    end

endmodule

// File: rtl/flash_pwr_select.sv
module flash_pwr_select
    import flash_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      accept,
    input  op_class_t cls,
    output logic      cs_rise,
    output logic      pend_dpd,
    output logic      pend_rel
);

    logic cs_q;

    assign cs_rise = cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q     <= cs_n;
            pend_dpd <= 1'b0;
            pend_rel <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                pend_dpd <= 1'b0;
                pend_rel <= 1'b0;
            end else if (accept) begin
                pend_dpd <= cls.is_dpd;
                pend_rel <= cls.is_rel;
            end
        end
    end

endmodule

// File: rtl/flash_pwr_fsm.sv
module flash_pwr_fsm
    import flash_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     cs_rise,
    input  logic     pend_dpd,
    input  logic     pend_rel,
    input  logic     engine_busy,
    output pm_mode_e cur_mode
);

    pm_mode_e nxt_mode;
    pm_mode_e idle_mode;

    assign idle_mode = engine_busy ? PM_ACTIVE : PM_STANDBY;

    always_comb begin
        nxt_mode = cur_mode;
        unique case (cur_mode)
            PM_DEEP: begin
                if (cs_rise && pend_rel) nxt_mode = PM_STANDBY;
            end
            default: begin
                if (cs_rise && pend_dpd) nxt_mode = PM_DEEP;
                else if (!cs_n)          nxt_mode = PM_ACTIVE;
                else                     nxt_mode = idle_mode;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= cs_n ? PM_STANDBY : PM_ACTIVE;
        end else begin
            cur_mode <= nxt_mode;
        end
    end

endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import flash_pwr_pkg::*;
#(
    parameter op_t DPD_OP = 8'hB9,
    parameter op_t REL_OP = 8'hAB
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            dev_rst_n,
    input  logic            instr_valid,
    input  logic [OP_W-1:0] instr_op,
    input  logic            engine_busy,
    output logic [MODE_W-1:0] mode,
    output logic            instr_accept,
    output logic            write_protect
);

    pm_mode_e  cur_mode;
    op_class_t cls;
    logic      accept;
    logic      cs_rise;
    logic      pend_dpd;
    logic      pend_rel;

    flash_pwr_decode #(.DPD_OP(DPD_OP), .REL_OP(REL_OP)) u_decode (
        .cur_mode    (cur_mode),
        .cs_n        (cs_n),
        .dev_rst_n   (dev_rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .engine_busy (engine_busy),
        .cls         (cls),
        .accept      (accept)
    );

    flash_pwr_select u_select (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .accept   (accept),
        .cls      (cls),
        .cs_rise  (cs_rise),
        .pend_dpd (pend_dpd),
        .pend_rel (pend_rel)
    );

    flash_pwr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .cs_rise     (cs_rise),
        .pend_dpd    (pend_dpd),
        .pend_rel    (pend_rel),
        .engine_busy (engine_busy),
        .cur_mode    (cur_mode)
    );

    assign mode          = cur_mode;
    assign instr_accept  = accept;
    assign write_protect = !dev_rst_n;

endmodule

// File: rtl/flash_pwr_ctrl_chk.sv
module flash_pwr_ctrl_chk
    import flash_pwr_pkg::*;
#(
    parameter op_t DPD_OP = 8'hB9,
    parameter op_t REL_OP = 8'hAB
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              dev_rst_n,
    input logic              instr_valid,
    input logic [OP_W-1:0]   instr_op,
    input logic              engine_busy,
    input logic [MODE_W-1:0] mode,
    input logic              instr_accept,
    input logic              write_protect
);

    a_r1_selected_active: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && mode != PM_DEEP) |=> (mode == PM_ACTIVE));

    a_r2_busy_keeps_active: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && engine_busy && mode == PM_ACTIVE) |=> (mode == PM_ACTIVE));

    a_r4_deep_only_release: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP && instr_accept) |-> (instr_op == REL_OP));

    a_r4_deep_sticks: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_DEEP && !(cs_n && !$past(cs_n))) |=> (mode == PM_DEEP));

    a_r6_no_write_in_reset: assert property (@(posedge clk) disable iff (rst)
        (!dev_rst_n && instr_accept) |-> (write_protect && !op_is_write(instr_op)));

    a_r7_no_dpd_when_busy: assert property (@(posedge clk) disable iff (rst)
        (instr_accept && instr_op == DPD_OP) |-> !engine_busy);

    a_r9_accept_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        instr_accept |-> (instr_valid && !cs_n));

    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        $countones(mode) <= 1);

endmodule

bind flash_pwr_ctrl flash_pwr_ctrl_chk #(.DPD_OP(DPD_OP), .REL_OP(REL_OP)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .dev_rst_n     (dev_rst_n),
    .instr_valid   (instr_valid),
    .instr_op      (instr_op),
    .engine_busy   (engine_busy),
    .mode          (mode),
    .instr_accept  (instr_accept),
    .write_protect (write_protect)
);

// File: tb/test_flash_pwr_ctrl.sv
`timescale 1ns/1ps
module test_flash_pwr_ctrl;

    localparam logic [1:0] M_ACT = 2'b00;
    localparam logic [1:0] M_STB = 2'b01;
    localparam logic [1:0] M_DPD = 2'b10;
    localparam logic [7:0] OP_DPD = 8'hB9;
    localparam logic [7:0] OP_REL = 8'hAB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       dev_rst_n = 1'b1;
    logic       instr_valid = 1'b0;
    logic [7:0] instr_op = 8'h00;
    logic       engine_busy = 1'b0;
    logic [1:0] mode;
    logic       instr_accept;
    logic       write_protect;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_pwr_ctrl i_flash_pwr_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .dev_rst_n(dev_rst_n),
        .instr_valid(instr_valid), .instr_op(instr_op), .engine_busy(engine_busy),
        .mode(mode), .instr_accept(instr_accept), .write_protect(write_protect)
    );

    // behavioural reference
    logic [1:0] m_mode;
    bit m_cs_prev, m_pdpd, m_prel;

    function automatic bit is_wr(input logic [7:0] op);
        return op inside {8'h06, 8'h02, 8'h0A, 8'hDB, 8'hD8};
    endfunction

    function automatic bit exp_accept();
        if (!instr_valid || cs_n) return 0;
        if (m_mode == M_DPD) return instr_op == OP_REL;
        if (instr_op == OP_DPD && engine_busy) return 0;
        if (is_wr(instr_op) && !dev_rst_n) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit rose, acc;
        rose = cs_n && !m_cs_prev;
        acc = exp_accept();
        if (rst) begin
            m_mode <= cs_n ? M_STB : M_ACT;
            m_pdpd <= 0; m_prel <= 0;
        end else begin
            if (m_mode == M_DPD) begin
                if (rose && m_prel) m_mode <= M_STB;
            end else if (rose && m_pdpd) m_mode <= M_DPD;
            else if (!cs_n) m_mode <= M_ACT;
            else m_mode <= engine_busy ? M_ACT : M_STB;
            if (cs_n) begin m_pdpd <= 0; m_prel <= 0; end
            else if (acc) begin
                m_pdpd <= (instr_op == OP_DPD);
                m_prel <= (instr_op == OP_REL);
            end
        end
        m_cs_prev <= cs_n;
    end

    task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R1 R2 R3 R5 R8 mode", mode, m_mode);
            chk("R4 R6 R7 R9 accept", {1'b0, instr_accept}, {1'b0, exp_accept()});
            chk("R6 write_protect", {1'b0, write_protect}, {1'b0, !dev_rst_n});
        end
    end

    task automatic drive(input bit c, input bit v, input logic [7:0] op);
        @(negedge clk);
        cs_n = c; instr_valid = v; instr_op = op;
    endtask

    task automatic after_edge();
        @(posedge clk); #1.5;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset with cs high
        repeat (3) @(posedge clk);
        after_edge(); chk("R8 standby after reset", mode, M_STB);
        @(negedge clk) cs_n = 0;
        after_edge(); chk("R8 active when selected in reset", mode, M_ACT);
        @(negedge clk) begin rst = 0; cs_n = 1; engine_busy = 1; end
        // R2: busy keeps active after deselect
        repeat (4) after_edge();
        chk("R2 busy holds active", mode, M_ACT);
        @(negedge clk) engine_busy = 0;
        after_edge(); chk("R2 standby after busy ends", mode, M_STB);
        // R1
        drive(0, 0, 8'h00); after_edge(); chk("R1 selected is active", mode, M_ACT);
        // R3 collided with busy at the rising edge
        drive(0, 1, OP_DPD); #1; chk("R3 dpd accepted", {1'b0, instr_accept}, 2'b01);
        drive(0, 0, 8'h00);
        drive(1, 0, 8'h00); engine_busy = 1;
        after_edge(); chk("R3 deep power-down on cs rise", mode, M_DPD);
        @(negedge clk) engine_busy = 0;
        // R4
        drive(0, 1, 8'h02); #1; chk("R4 write ignored in deep", {1'b0, instr_accept}, 2'b00);
        drive(0, 1, 8'h05); #1; chk("R4 read status ignored in deep", {1'b0, instr_accept}, 2'b00);
        drive(1, 0, 8'h00); after_edge(); chk("R4 stays deep", mode, M_DPD);
        // R5
        drive(0, 1, OP_REL); #1; chk("R5 release accepted", {1'b0, instr_accept}, 2'b01);
        drive(0, 0, 8'h00); after_edge(); chk("R4 deep while selected", mode, M_DPD);
        drive(1, 0, 8'h00); after_edge(); chk("R5 standby after release", mode, M_STB);
        // R6
        dev_rst_n = 0;
        drive(0, 1, 8'h02); #1; chk("R6 program blocked", {1'b0, instr_accept}, 2'b00);
        chk("R6 write_protect high", {1'b0, write_protect}, 2'b01);
        drive(0, 1, 8'h03); #1; chk("R6 read still accepted", {1'b0, instr_accept}, 2'b01);
        drive(1, 0, 8'h00); dev_rst_n = 1;
        // R7
        drive(0, 0, 8'h00); engine_busy = 1;
        drive(0, 1, OP_DPD); #1; chk("R7 dpd refused when busy", {1'b0, instr_accept}, 2'b00);
        drive(1, 0, 8'h00); after_edge(); chk("R7 no deep when busy", mode, M_ACT);
        @(negedge clk) engine_busy = 0;
        // R9
        drive(0, 1, OP_DPD); drive(0, 1, 8'h05);
        drive(1, 1, 8'h05); #1; chk("R9 no accept when deselected", {1'b0, instr_accept}, 2'b00);
        after_edge(); chk("R9 later opcode cancels dpd", mode, M_STB);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) cs_n = ~cs_n;
            instr_valid = $urandom_range(0, 2) == 0;
            case ($urandom_range(0, 4))
                0: instr_op = OP_DPD;
                1: instr_op = OP_REL;
                2: instr_op = 8'h02;
                3: instr_op = 8'hD8;
                default: instr_op = 8'($urandom);
            endcase
            if ($urandom_range(0, 5) == 0) engine_busy = ~engine_busy;
            if ($urandom_range(0, 9) == 0) dev_rst_n = ~dev_rst_n;
        end
        @(posedge clk); #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule